// File: doc/BRIEF.md
# PCIe MSI Receiver with Interrupt Latch

This block sits beside a PCIe root port and snoops each inbound memory write. The write arrives on a reduced interface: a valid strobe, a 64-bit address and a 32-bit data word. Software programs a target address, an enable bit and a data pattern. A write that reaches the target, that lies outside the inbound memory window and whose data matches the pattern is taken as a message signalled interrupt. The low data bits of such a write select a vector, and the block latches that vector into a 32-bit pending register.

A 32-bit register port holds the configuration and an interrupt group made of status, set, clear, mask status, mask set and mask clear. One level interrupt line goes to the CPU. It is high while any pending vector is unmasked.

The data pattern register sets how many vectors exist. The trailing zero bits of its mask half give a power-of-two vector count. The vectors always take the top bits of the status register, so a 32-vector setup uses bits 0 to 31 and an 8-vector setup uses bits 24 to 31.

Top module: `msi_rx_top`

## Requirements
- R1: After reset the status register reads 0, the mask status register reads 0xFFFFFFFF (all vectors masked), `irq` is 0, and the target, address-high and data-pattern registers read 0, so MSI is disabled.
- R2: A write counts as an address hit only when its address bits 63:2 equal {addr-high register, addr-low register bits 31:2}, and only while bit 0 of the addr-low register (the enable) is 1. With the enable at 0 a write to the target sets no status bit.
- R3: For a hit, let M be bits 31:16 and V be bits 15:0 of the data-pattern register. The write is accepted only when (data[15:0] & M) == (V & M). Data bits 31:16 are ignored, and a write that fails the match sets no status bit.
- R4: Let t be the number of trailing zero bits of M, capped at 5, and let N = 2^t. An accepted write sets status bit 32 − N + (data[15:0] mod N). So mask 0xFFE0 maps vector n to bit n, and mask 0xFFF8 maps vector n to bit 24+n.
- R5: A write whose address satisfies (addr & ~win_mask) == (win_base & ~win_mask) while `win_en` is 1 is inbound memory traffic and never sets a status bit, even when it equals the target.
- R6: Writing to offset 0x04 sets every status bit whose data bit is 1. Writing to 0x08 clears every such bit. Status reads at 0x00, writes to 0x00 are ignored, and status changes in no other way.
- R7: Writing to 0x10 masks every vector whose data bit is 1. Writing to 0x14 unmasks them. Mask status reads at 0x0C. Masked vectors still latch into status.
- R8: `irq` equals the OR of the status bits that are not masked. A status or mask change made at a clock edge shows on `irq` right after that edge.
- R9: When an accepted write and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R10: The addr-low (0x20), addr-high (0x24) and data-pattern (0x28) registers read back what was written. Offsets 0x04, 0x08, 0x10 and 0x14 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Inbound memory write present this cycle |
| in_addr | input | 64 | Address of the inbound write |
| in_data | input | 32 | First data word of the inbound write |
| win_en | input | 1 | Inbound memory window enabled |
| win_base | input | 64 | Inbound window base address |
| win_mask | input | 64 | Address bits ignored by the window compare (size − 1) |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| irq | output | 1 | Level interrupt to the CPU |

## Verification
The bench goes after the cases a decoder most easily gets wrong. A target that lies inside the window must be dropped, and a design that checks the target first would latch it. A clear that lands with an arrival on the same bit must leave the bit set, and a design that lets the clear win would lose the interrupt. When the data mask is switched from 32 to 8 vectors, the vectors must move to bits 24 and up, and a design that counts trailing zeros wrongly would light the wrong bit. Address low bits, unmatched data, ignored upper data bits, a disabled target and writes to the read-only status register are also probed, and a design that got any of these wrong would either latch a vector it should drop or miss one it should take.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;

  // Register byte offsets; the interrupt group layout is fixed by software.
  localparam logic [7:0] OFS_STAT    = 8'h00;
  localparam logic [7:0] OFS_SET     = 8'h04;
  localparam logic [7:0] OFS_CLR     = 8'h08;
  localparam logic [7:0] OFS_MSTAT   = 8'h0C;
  localparam logic [7:0] OFS_MSET    = 8'h10;
  localparam logic [7:0] OFS_MCLR    = 8'h14;
  localparam logic [7:0] OFS_TGT_LO  = 8'h20;
  localparam logic [7:0] OFS_TGT_HI  = 8'h24;
  localparam logic [7:0] OFS_DPAT    = 8'h28;

  // Write strobes into the interrupt register group.
  typedef struct packed {
    logic set;
    logic clr;
    logic mset;
    logic mclr;
  } irq_wr_t;

endpackage

// File: rtl/msi_addr_decode.sv
module msi_addr_decode #(
  parameter int ADDR_W = 64
) (
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic              msi_en,
  input  logic              win_en,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_mask,
  output logic              win_hit,
  output logic              addr_hit
);

  logic in_window;
  logic tgt_match;
  logic unused_low;

  // Dword granular target compare; the two lowest address bits are ignored.
  assign unused_low = ^{wr_addr[1:0], tgt_addr[1:0]};

  always_comb begin
    in_window = win_en && ((wr_addr & ~win_mask) == (win_base & ~win_mask));
    tgt_match = (wr_addr[ADDR_W-1:2] == tgt_addr[ADDR_W-1:2]);
    win_hit   = wr_valid && in_window;
    // Memory window takes priority over message decoding.
    addr_hit  = wr_valid && msi_en && tgt_match && !in_window;
  end

endmodule

// File: rtl/msi_vector_map.sv
module msi_vector_map #(
  parameter int STAT_W = 32,
  parameter int MD_W   = 16
) (
  input  logic              addr_hit,
  input  logic [MD_W-1:0]   wr_data,
  input  logic [MD_W-1:0]   dp_mask,
  input  logic [MD_W-1:0]   dp_value,
  output logic              arr_vld,
  output logic [STAT_W-1:0] arr_vec
);

  localparam int IDX_W = $clog2(STAT_W);
  localparam int CNT_W = IDX_W + 1;

  logic [CNT_W-1:0] tz;
  logic [CNT_W-1:0] nvec;
  logic [CNT_W-1:0] vec;
  logic [CNT_W-1:0] bitpos;
  logic             data_ok;

  always_comb begin
    // Trailing zero count of the mask, capped at the index width.
    tz = CNT_W'(IDX_W);
    for (int i = IDX_W - 1; i >= 0; i--) begin
      if (dp_mask[i]) tz = CNT_W'(i);
    end
    nvec    = CNT_W'(1) << tz;
    vec     = wr_data[CNT_W-1:0] & (nvec - CNT_W'(1));
    bitpos  = CNT_W'(STAT_W) - nvec + vec;
    data_ok = ((wr_data ^ dp_value) & dp_mask) == '0;
    arr_vld = addr_hit && data_ok;
    arr_vec = arr_vld ? (STAT_W'(1) << bitpos) : '0;
  end

endmodule

// File: rtl/msi_int_regs.sv
module msi_int_regs
  import msi_rx_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irq_wr_t           wr_stb,
  input  logic [STAT_W-1:0] wdata,
  input  logic              arr_vld,
  input  logic [STAT_W-1:0] arr_vec,
  output logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] mask
);

  logic [STAT_W-1:0] stat_nxt;
  logic [STAT_W-1:0] mask_nxt;
  logic              stat_en;
  logic              mask_en;

  always_comb begin
    stat_nxt = status;
    if (wr_stb.set) stat_nxt = stat_nxt | wdata;
    if (wr_stb.clr) stat_nxt = stat_nxt & ~wdata;
    // Arrival applied last so it survives a simultaneous clear.
    if (arr_vld)    stat_nxt = stat_nxt | arr_vec;
    stat_en = wr_stb.set || wr_stb.clr || arr_vld;

    mask_nxt = mask;
    if (wr_stb.mset) mask_nxt = mask_nxt | wdata;
    if (wr_stb.mclr) mask_nxt = mask_nxt & ~wdata;
    mask_en = wr_stb.mset || wr_stb.mclr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
    end else if (stat_en) begin
      status <= stat_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '1;
    end else if (mask_en) begin
      mask <= mask_nxt;
    end
  end

endmodule

// File: rtl/msi_rx_top.sv
module msi_rx_top
  import msi_rx_pkg::*;
#(
  parameter int REG_DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2*REG_DW-1:0] in_addr,
  input  logic [REG_DW-1:0]   in_data,
  input  logic                win_en,
  input  logic [2*REG_DW-1:0] win_base,
  input  logic [2*REG_DW-1:0] win_mask,
  input  logic                reg_en,
  input  logic                reg_we,
  input  logic [7:0]          reg_addr,
  input  logic [REG_DW-1:0]   reg_wdata,
  output logic [REG_DW-1:0]   reg_rdata,
  output logic                irq
);

  localparam int ADDR_W = 2 * REG_DW;
  localparam int STAT_W = REG_DW;
  localparam int MD_W   = REG_DW / 2;

  // Reset synchroniser: asserts at once, releases on the clock.
  logic rst_meta;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {rst_sync_n, rst_meta} <= 2'b00;
    end else begin
      {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
    end
  end

  // Configuration registers.
  logic [REG_DW-1:0] tgt_lo, tgt_hi, dpat;
  logic [REG_DW-1:0] tgt_lo_nxt, tgt_hi_nxt, dpat_nxt;
  logic              cfg_en;
  logic              wr_any;
  irq_wr_t           wr_stb;

  always_comb begin
    wr_any      = reg_en && reg_we;
    wr_stb.set  = wr_any && (reg_addr == OFS_SET);
    wr_stb.clr  = wr_any && (reg_addr == OFS_CLR);
    wr_stb.mset = wr_any && (reg_addr == OFS_MSET);
    wr_stb.mclr = wr_any && (reg_addr == OFS_MCLR);

    tgt_lo_nxt = tgt_lo;
    tgt_hi_nxt = tgt_hi;
    dpat_nxt   = dpat;
    cfg_en     = 1'b0;
    if (wr_any) begin
      case (reg_addr)
        OFS_TGT_LO: begin tgt_lo_nxt = reg_wdata; cfg_en = 1'b1; end
        OFS_TGT_HI: begin tgt_hi_nxt = reg_wdata; cfg_en = 1'b1; end
        OFS_DPAT:   begin dpat_nxt   = reg_wdata; cfg_en = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tgt_lo <= '0;
      tgt_hi <= '0;
      dpat   <= '0;
    end else if (cfg_en) begin
      tgt_lo <= tgt_lo_nxt;
      tgt_hi <= tgt_hi_nxt;
      dpat   <= dpat_nxt;
    end
  end

  // Decode path.
  logic              msi_en;
  logic [ADDR_W-1:0] tgt_addr;
  logic              win_hit;
  logic              addr_hit;
  logic              arr_vld;
  logic [STAT_W-1:0] arr_vec;
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] mask;
  logic              unused_hi_data;

  assign msi_en         = tgt_lo[0];
  assign tgt_addr       = {tgt_hi, tgt_lo};
  assign unused_hi_data = ^in_data[REG_DW-1:MD_W];

  msi_addr_decode #(.ADDR_W(ADDR_W)) u_addr (
    .wr_valid (in_valid),
    .wr_addr  (in_addr),
    .tgt_addr (tgt_addr),
    .msi_en   (msi_en),
    .win_en   (win_en),
    .win_base (win_base),
    .win_mask (win_mask),
    .win_hit  (win_hit),
    .addr_hit (addr_hit)
  );

  msi_vector_map #(.STAT_W(STAT_W), .MD_W(MD_W)) u_vec (
    .addr_hit (addr_hit),
    .wr_data  (in_data[MD_W-1:0]),
    .dp_mask  (dpat[REG_DW-1:MD_W]),
    .dp_value (dpat[MD_W-1:0]),
    .arr_vld  (arr_vld),
    .arr_vec  (arr_vec)
  );

  msi_int_regs #(.STAT_W(STAT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_stb  (wr_stb),
    .wdata   (reg_wdata),
    .arr_vld (arr_vld),
    .arr_vec (arr_vec),
    .status  (status),
    .mask    (mask)
  );

  always_comb begin
    case (reg_addr)
      OFS_STAT:   reg_rdata = status;
      OFS_MSTAT:  reg_rdata = mask;
      OFS_TGT_LO: reg_rdata = tgt_lo;
      OFS_TGT_HI: reg_rdata = tgt_hi;
      OFS_DPAT:   reg_rdata = dpat;
      default:    reg_rdata = '0;
    endcase
  end

  assign irq = |(status & ~mask);

endmodule

// File: rtl/msi_rx_chk.sv
module msi_rx_chk
  import msi_rx_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              win_hit,
  input logic              msi_en,
  input logic              arr_vld,
  input logic [STAT_W-1:0] arr_vec,
  input logic              reg_en,
  input logic              reg_we,
  input logic [7:0]        reg_addr,
  input logic [STAT_W-1:0] reg_wdata,
  input logic [STAT_W-1:0] status,
  input logic [STAT_W-1:0] mask
);

  logic wr_set, wr_clr, wr_mset, wr_mclr;
  assign wr_set  = reg_en && reg_we && (reg_addr == OFS_SET);
  assign wr_clr  = reg_en && reg_we && (reg_addr == OFS_CLR);
  assign wr_mset = reg_en && reg_we && (reg_addr == OFS_MSET);
  assign wr_mclr = reg_en && reg_we && (reg_addr == OFS_MCLR);

  // R5: window traffic is never decoded
  a_r5_window_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> !arr_vld);

  // R2: disabled target yields no arrival
  a_r2_disabled_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !msi_en |-> !arr_vld);

  // R4: one vector per accepted write
  a_r4_single_vector: assert property (@(posedge clk) disable iff (!rst_n)
    arr_vld |-> ($countones(arr_vec) == 1));

  // R9: an arrival is latched whatever else happens that cycle
  a_r9_arrival_latches: assert property (@(posedge clk) disable iff (!rst_n)
    arr_vld |=> ((status & $past(arr_vec)) == $past(arr_vec)));

  // R6: clear removes the written bits when no arrival competes
  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !arr_vld) |=> ((status & $past(reg_wdata)) == '0));

  // R6: status holds when nothing touches it
  a_r6_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!arr_vld && !wr_set && !wr_clr) |=> $stable(status));

  // R7: mask set and clear
  a_r7_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> ((mask & $past(reg_wdata)) == $past(reg_wdata)));

  a_r7_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mclr |=> ((mask & $past(reg_wdata)) == '0));

endmodule

bind msi_rx_top msi_rx_chk #(.STAT_W(STAT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .win_hit   (win_hit),
  .msi_en    (msi_en),
  .arr_vld   (arr_vld),
  .arr_vec   (arr_vec),
  .reg_en    (reg_en),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .status    (status),
  .mask      (mask)
);

// File: tb/msi_rx_top_tb.sv
module msi_rx_top_tb;

  localparam int CLK_PERIOD = 10;

  localparam logic [7:0] A_STAT = 8'h00, A_SET = 8'h04, A_CLR = 8'h08,
                         A_MSTAT = 8'h0C, A_MSET = 8'h10, A_MCLR = 8'h14,
                         A_LO = 8'h20, A_HI = 8'h24, A_DP = 8'h28;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_addr;
  logic [31:0] in_data;
  logic        win_en;
  logic [63:0] win_base;
  logic [63:0] win_mask;
  logic        reg_en;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // Bench model
  logic [31:0] m_stat, m_mask, m_lo, m_hi, m_dp;
  localparam logic [63:0] TGT = 64'h0000_000F_FFFF_F000;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_rx_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_data(in_data), .win_en(win_en), .win_base(win_base),
    .win_mask(win_mask), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  function automatic int exp_bit(input logic [63:0] a, input logic [31:0] d);
    logic [15:0] mk, mv;
    int t, n;
    if (win_en && ((a & ~win_mask) == (win_base & ~win_mask))) return -1;
    if (!m_lo[0]) return -1;
    if (a[63:2] != {m_hi, m_lo[31:2]}) return -1;
    mk = m_dp[31:16];
    mv = m_dp[15:0];
    if ((d[15:0] & mk) != (mv & mk)) return -1;
    t = 0;
    while (t < 5 && !mk[t]) t++;
    n = 1 << t;
    return 32 - n + (int'(d[15:0]) % n);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 v = reg_rdata;
    reg_en = 1'b0;
  endtask

  // One clock with an optional register write and an optional inbound write.
  task automatic cyc(input bit rv, input logic [7:0] ra, input logic [31:0] rdat,
                     input bit mv, input logic [63:0] ma, input logic [31:0] md);
    int eb;
    @(negedge clk);
    reg_en = rv; reg_we = rv; reg_addr = ra; reg_wdata = rdat;
    in_valid = mv; in_addr = ma; in_data = md;
    eb = mv ? exp_bit(ma, md) : -1;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0; in_valid = 1'b0;
    if (rv) begin
      case (ra)
        A_SET:  m_stat = m_stat | rdat;
        A_CLR:  m_stat = m_stat & ~rdat;
        A_MSET: m_mask = m_mask | rdat;
        A_MCLR: m_mask = m_mask & ~rdat;
        A_LO:   m_lo = rdat;
        A_HI:   m_hi = rdat;
        A_DP:   m_dp = rdat;
        default: ;
      endcase
    end
    if (eb >= 0) m_stat[eb] = 1'b1;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 64'd0, 32'd0);
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d);
    cyc(1'b0, 8'h00, 32'd0, 1'b1, a, d);
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    rd(A_STAT, v);  check({req, " status"}, v, m_stat);
    rd(A_MSTAT, v); check({req, " mask"}, v, m_mask);
    check({req, " irq"}, {31'd0, irq}, {31'd0, |(m_stat & ~m_mask)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd7031));
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_data = '0;
    reg_en = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    win_en = 1'b1; win_base = 64'd0; win_mask = 64'h0000_0000_FFFF_FFFF;
    m_stat = 32'd0; m_mask = 32'hFFFF_FFFF; m_lo = 0; m_hi = 0; m_dp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_STAT, v);  check("R1 status", v, 32'd0);
    rd(A_MSTAT, v); check("R1 mask", v, 32'hFFFF_FFFF);
    rd(A_LO, v);    check("R1 enable off", v, 32'd0);
    rd(A_DP, v);    check("R1 pattern", v, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R2 disabled target drops
    wreg(A_HI, TGT[63:32]);
    wreg(A_LO, TGT[31:0]);
    wreg(A_DP, 32'hFFE0_6540);
    msi(TGT, 32'h0000_6545);
    rd(A_STAT, v); check("R2 disabled", v, 32'd0);

    // R10 readback
    wreg(A_LO, TGT[31:0] | 32'd1);
    rd(A_LO, v);  check("R10 lo", v, 32'hFFFF_F001);
    rd(A_HI, v);  check("R10 hi", v, 32'h0000_000F);
    rd(A_DP, v);  check("R10 pattern", v, 32'hFFE0_6540);
    rd(A_SET, v); check("R10 set reads 0", v, 32'd0);

    // R4 32-vector mode, R7 masked still latches
    msi(TGT, 32'h0000_6545);
    rd(A_STAT, v); check("R4 vec5", v, 32'h0000_0020);
    check("R7 masked irq", {31'd0, irq}, 32'd0);
    wreg(A_MCLR, 32'h0000_0020);
    check("R8 irq up", {31'd0, irq}, 32'd1);
    rd(A_MSTAT, v); check("R7 mask clr", v, 32'hFFFF_FFDF);

    // R3 data match
    msi(TGT, 32'h0000_6645);
    rd(A_STAT, v); check("R3 mismatch", v, 32'h0000_0020);
    msi(TGT, 32'hABCD_6547);
    rd(A_STAT, v); check("R3 upper ignored", v, 32'h0000_00A0);

    // R2 address compare
    msi(TGT + 64'd4, 32'h0000_6541);
    rd(A_STAT, v); check("R2 addr miss", v, 32'h0000_00A0);
    msi(TGT | 64'd3, 32'h0000_6541);
    rd(A_STAT, v); check("R2 low bits ignored", v, 32'h0000_00A2);

    // R6 set / clear / status write ignored
    wreg(A_CLR, 32'h0000_0020);
    rd(A_STAT, v); check("R6 clear", v, 32'h0000_0082);
    check("R8 irq down", {31'd0, irq}, 32'd0);
    wreg(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); check("R6 status write ignored", v, 32'h0000_0082);
    wreg(A_SET, 32'h0000_0100);
    rd(A_STAT, v); check("R6 set", v, 32'h0000_0182);

    // R9 arrival beats clear
    cyc(1'b1, A_CLR, 32'h0000_0002, 1'b1, TGT, 32'h0000_6541);
    rd(A_STAT, v); check("R9 arrival wins", v, 32'h0000_0182);

    // R4 8-vector mode
    wreg(A_DP, 32'hFFF8_6540);
    msi(TGT, 32'h0000_6543);
    rd(A_STAT, v); check("R4 8vec bit27", v, 32'h0800_0182);
    msi(TGT, 32'h0000_6547);
    rd(A_STAT, v); check("R4 8vec bit31", v, 32'h8800_0182);

    // R5 window priority
    wreg(A_CLR, 32'hFFFF_FFFF);
    wreg(A_HI, 32'd0);
    wreg(A_LO, 32'h8000_0001);
    msi(64'h0000_0000_8000_0000, 32'h0000_6540);
    rd(A_STAT, v); check("R5 window blocks", v, 32'd0);
    win_en = 1'b0;
    msi(64'h0000_0000_8000_0000, 32'h0000_6540);
    rd(A_STAT, v); check("R5 window off", v, 32'h0100_0000);
    win_en = 1'b1;
    wreg(A_HI, TGT[63:32]);
    wreg(A_LO, TGT[31:0] | 32'd1);
    check_all("R8 directed");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [15:0] mk;
      op = $urandom_range(0, 5);
      mk = m_dp[31:16];
      case (op)
        0, 1: msi(TGT | 64'($urandom_range(0, 3)),
                  {$urandom, 16'h0} >> 16 << 16 |
                  32'((m_dp[15:0] & mk) | (16'($urandom) & ~mk)));
        2: msi({$urandom, $urandom}, $urandom);
        3: begin
          logic [7:0] ra;
          int s;
          s = $urandom_range(0, 3);
          ra = (s == 0) ? A_SET : (s == 1) ? A_CLR : (s == 2) ? A_MSET : A_MCLR;
          wreg(ra, $urandom & $urandom);
        end
        4: begin
          logic [15:0] nm;
          int s;
          s = $urandom_range(0, 4);
          nm = (s == 0) ? 16'hFFE0 : (s == 1) ? 16'hFFF8 : (s == 2) ? 16'hFFFC :
               (s == 3) ? 16'hFFFF : 16'hFFF0;
          wreg(A_DP, {nm, 16'h6540});
        end
        default: cyc(1'b1, A_CLR, $urandom, 1'b1, TGT, $urandom);
      endcase
      check_all("R8 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule